// File: doc/BRIEF.md
# Serial Converter Command and Result Port

This block is the digital side of an eight-input, ten-bit successive-approximation converter. It runs entirely on the host's serial clock. While chip select is low, it watches the data input for the first logic 1. That start bit opens an eight-bit command word. The command word selects the input channel, the polarity (straight binary or two's complement), single-ended or pseudo-differential input, and one of four power modes. These decoded settings are held on output ports until the next complete command word arrives.

When a command word completes, the block raises a one-cycle strobe. It then shifts twelve bit decisions out MSB first: ten result bits followed by two sub-LSB bits. In this model, the decisions come from a preloaded 12-bit sample word that is latched when the command word completes. A bipolar conversion is emitted in two's complement by inverting the MSB of the offset code. A new start bit may overlap the conversion still running once the decision of weight 4 is on the output, which allows a 16-clock repeat rate. The data and strobe outputs each come with a drive-enable for an external tri-state pad.

The receiver has two states. It sits in RX_IDLE until it accepts a start bit, moves to RX_SHIFT, and returns to RX_IDLE on the edge that takes in the eighth bit. The converter has three states. CV_IDLE moves to CV_STROBE when a command word completes. CV_STROBE always moves to CV_RUN. CV_RUN stays put until the weight-0 decision has been shown, then returns to CV_IDLE. A synchronous reset, or the shutdown input held low, forces both machines to their idle state from any state.

Top module: `adc_serial_port`

## Requirements
- R1: When `rst` is high at a clock edge, or `shdn_n` is low at a clock edge, both machines return to idle. After that edge, `dout`, `strobe`, `chan_sel`, `unipolar` and `single_ended` are 0, and `pwr_mode` is 00 (full power-down).
- R2: Zeros on `din` are ignored while idle. The first 1 sampled on `din` with `cs_n` low and the receiver idle is the start bit, and it becomes bit 7 of the command word. A 1 sampled while `cs_n` is high starts nothing.
- R3: The command word is taken MSB first. Bit 7 is the start bit. Bits 6:4 give the channel, bit 3 is unipolar (1) or bipolar (0), bit 2 is single-ended (1), and bits 1:0 give the power mode: 00 full down, 01 fast down, 10 reduced, 11 normal. The outputs take the new values on the edge that samples bit 0 and hold them until the next complete word.
- R4: `strobe` is high for exactly the one cycle after the edge that samples bit 0 of the command word, and low at all other times.
- R5: `dout` is 0 while a command word is being received and during the strobe cycle. The 12 decisions then appear MSB first, one on each of the next 12 rising edges. After the last decision, `dout` returns to 0.
- R6: In unipolar mode the decisions equal `sample_in` as latched on the edge that completes the command word. In bipolar mode they equal that value with its MSB inverted.
- R7: `dout_oe` and `strobe_oe` are high exactly while `cs_n` is low. Raising `cs_n` does not stop a conversion that is already running.
- R8: During a conversion, a 1 on `din` is ignored until the decision of weight 4 is on `dout`. From then on it is accepted as a start bit, so a start bit sent 16 clocks after the previous one is honoured.
- R9: Pulling `shdn_n` low aborts a conversion in progress. No further decisions are shifted out, and the result of that conversion is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host serial clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| din | input | 1 | Serial command input |
| shdn_n | input | 1 | Shutdown, active low; aborts and clears |
| sample_in | input | 12 | Preloaded offset-binary decision word |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Drive enable for `dout` |
| strobe | output | 1 | End-of-command strobe |
| strobe_oe | output | 1 | Drive enable for `strobe` |
| chan_sel | output | 3 | Decoded channel |
| unipolar | output | 1 | Decoded polarity, 1 = unipolar |
| single_ended | output | 1 | Decoded input mode, 1 = single-ended |
| pwr_mode | output | 2 | Decoded power mode |

## Verification
The bench builds the block with its default parameters: ten result bits, two sub-LSB bits, a three-bit channel field, and an overlap threshold of decision weight 4. These values give a 12-decision word and place the earliest accepted overlapping start bit exactly 16 clocks after the previous one. That makes it possible to probe the acceptance boundary one clock on either side. A scoreboard compares every emitted word and its decoded fields against values computed from the command bits and the sample word. The stimulus includes back-to-back pipelined frames, a rejected early start, chip select raised mid-conversion, and a shutdown abort.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

    typedef enum logic [1:0] {
        PM_FULL_DOWN = 2'b00,
        PM_FAST_DOWN = 2'b01,
        PM_REDUCED   = 2'b10,
        PM_NORMAL    = 2'b11
    } pwr_mode_t;

    typedef enum logic {
        RX_IDLE,
        RX_SHIFT
    } rx_state_t;

    typedef enum logic [1:0] {
        CV_IDLE,
        CV_STROBE,
        CV_RUN
    } cv_state_t;

endpackage

// File: rtl/cmd_receiver.sv
module cmd_receiver
    import adc_port_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              cs_n,
    input  logic              din,
    input  logic              start_ok,
    output logic              word_done,
    output logic [CTRL_W-1:0] word_val
);
    localparam int CW = $clog2(CTRL_W + 1);
    localparam logic [CW-1:0] LAST_HELD = CW'(CTRL_W - 1);

    rx_state_t         state, state_nx;
    logic [CTRL_W-2:0] held;
    logic [CW-1:0]     cnt;

    logic take_start;
    assign take_start = (state == RX_IDLE) && !cs_n && din && start_ok;
    assign word_done  = (state == RX_SHIFT) && (cnt == LAST_HELD);
    assign word_val   = {held, din};

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (take_start) state_nx = RX_SHIFT;
            RX_SHIFT: if (word_done)  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) state <= RX_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            held <= '0;
            cnt  <= '0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    if (take_start) begin
                        held <= {{(CTRL_W-2){1'b0}}, 1'b1};
                        cnt  <= CW'(1);
                    end
                end
                RX_SHIFT: begin
                    held <= {held[CTRL_W-3:0], din};
                    cnt  <= word_done ? '0 : cnt + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import adc_port_pkg::*;
#(
    parameter int NDEC     = 12,
    parameter int OPEN_IDX = 4
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            go,
    input  logic            go_unipolar,
    input  logic [NDEC-1:0] sample,
    output logic            dout,
    output logic            strobe,
    output logic            start_ok
);
    localparam int PW = $clog2(NDEC);
    localparam logic [PW-1:0] TOP_IDX  = PW'(NDEC - 1);
    localparam logic [PW-1:0] OPEN_POS = PW'(OPEN_IDX);

    cv_state_t       state, state_nx;
    logic [NDEC-1:0] word;
    logic [PW-1:0]   pos;

    assign start_ok = (state == CV_IDLE) || ((state == CV_RUN) && (pos <= OPEN_POS));

    always_comb begin
        state_nx = state;
        unique case (state)
            CV_IDLE:   if (go) state_nx = CV_STROBE;
            CV_STROBE: state_nx = CV_RUN;
            CV_RUN:    if (pos == '0) state_nx = CV_IDLE;
            default:   state_nx = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) state <= CV_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            word   <= '0;
            pos    <= '0;
            dout   <= 1'b0;
            strobe <= 1'b0;
        end else begin
            unique case (state)
                CV_IDLE: begin
                    dout   <= 1'b0;
                    strobe <= go;
                    if (go)
                        word <= go_unipolar ? sample : {~sample[NDEC-1], sample[NDEC-2:0]};
                end
                CV_STROBE: begin
                    strobe <= 1'b0;
                    dout   <= word[NDEC-1];
                    pos    <= TOP_IDX;
                end
                CV_RUN: begin
                    if (pos == '0) begin
                        dout <= 1'b0;
                    end else begin
                        pos  <= pos - 1'b1;
                        dout <= word[pos - 1'b1];
                    end
                end
                default: begin
                    dout   <= 1'b0;
                    strobe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_port_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int SUB_W    = 2,
    parameter int CH_W     = 3,
    parameter int OPEN_IDX = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs_n,
    input  logic                    din,
    input  logic                    shdn_n,
    input  logic [DATA_W+SUB_W-1:0] sample_in,
    output logic                    dout,
    output logic                    dout_oe,
    output logic                    strobe,
    output logic                    strobe_oe,
    output logic [CH_W-1:0]         chan_sel,
    output logic                    unipolar,
    output logic                    single_ended,
    output logic [1:0]              pwr_mode
);
    localparam int NDEC   = DATA_W + SUB_W;
    localparam int CTRL_W = CH_W + 5;
    localparam int CH_HI  = CTRL_W - 2;

    logic              clr;
    logic              rx_done;
    logic [CTRL_W-1:0] rx_word;
    logic              conv_open;

    assign clr = rst || !shdn_n;

    cmd_receiver #(.CTRL_W(CTRL_W)) u_rx (
        .clk       (clk),
        .clr       (clr),
        .cs_n      (cs_n),
        .din       (din),
        .start_ok  (conv_open),
        .word_done (rx_done),
        .word_val  (rx_word)
    );

    sar_sequencer #(.NDEC(NDEC), .OPEN_IDX(OPEN_IDX)) u_sar (
        .clk         (clk),
        .clr         (clr),
        .go          (rx_done),
        .go_unipolar (rx_word[3]),
        .sample      (sample_in),
        .dout        (dout),
        .strobe      (strobe),
        .start_ok    (conv_open)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            chan_sel     <= '0;
            unipolar     <= 1'b0;
            single_ended <= 1'b0;
            pwr_mode     <= PM_FULL_DOWN;
        end else if (rx_done) begin
            chan_sel     <= rx_word[CH_HI -: CH_W];
            unipolar     <= rx_word[3];
            single_ended <= rx_word[2];
            pwr_mode     <= rx_word[1:0];
        end
    end

    assign dout_oe   = !cs_n;
    assign strobe_oe = !cs_n;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            shdn_n,
    input logic            rx_done,
    input logic            strobe,
    input logic            dout,
    input logic [CH_W-1:0] chan_sel,
    input logic            unipolar,
    input logic            single_ended,
    input logic [1:0]      pwr_mode
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (strobe && shdn_n) |=> !strobe); // R4

    AST_STROBE_AFTER_WORD: assert property (@(posedge clk) disable iff (rst || !shdn_n)
        $rose(strobe) |-> $past(rx_done)); // R4

    AST_DOUT_QUIET_STROBE: assert property (@(posedge clk) disable iff (rst)
        strobe |-> !dout); // R5

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
        (!rx_done && shdn_n) |=> ($stable(chan_sel) && $stable(unipolar)
                                  && $stable(single_ended) && $stable(pwr_mode))); // R3

    AST_SHDN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> (pwr_mode == 2'b00 && !strobe && !dout && chan_sel == '0)); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pwr_mode == 2'b00 && !strobe && !dout)); // R1
endmodule

bind adc_serial_port adc_serial_port_chk #(.CH_W(CH_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .shdn_n       (shdn_n),
    .rx_done      (rx_done),
    .strobe       (strobe),
    .dout         (dout),
    .chan_sel     (chan_sel),
    .unipolar     (unipolar),
    .single_ended (single_ended),
    .pwr_mode     (pwr_mode)
);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        shdn_n = 1'b1;
    logic [11:0] sample_in = '0;
    logic        dout, dout_oe, strobe, strobe_oe, unipolar, single_ended;
    logic [2:0]  chan_sel;
    logic [1:0]  pwr_mode;

    always #(CLK_P/2) clk = ~clk;

    adc_serial_port uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .din(din), .shdn_n(shdn_n),
        .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe), .strobe(strobe),
        .strobe_oe(strobe_oe), .chan_sel(chan_sel), .unipolar(unipolar),
        .single_ended(single_ended), .pwr_mode(pwr_mode)
    );

    typedef struct {
        logic [11:0] word;
        logic [2:0]  ch;
        logic        uni;
        logic        sgl;
        logic [1:0]  pm;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   strobe_cnt = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input logic [2:0] ch, input logic uni, input logic sgl,
                              input logic [1:0] pm, input logic [11:0] smp, input int gap);
        exp_t e;
        logic [7:0] b;
        b = {1'b1, ch, uni, sgl, pm};
        e.word = uni ? smp : (smp ^ 12'h800);
        e.ch = ch; e.uni = uni; e.sgl = sgl; e.pm = pm;
        exp_q.push_back(e);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            din = b[i];
            if (i == 0) sample_in = smp;
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            din = 1'b0;
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            din = 1'b0;
        end
    endtask

    // Scoreboard monitor
    bit          shdn_hit = 0;
    bit          coll = 0;
    bit          tail = 0;
    int          ccount = 0;
    logic [11:0] got;
    exp_t        cur;

    always @(posedge clk) shdn_hit <= !shdn_n || rst;

    always @(negedge clk) begin
        if (shdn_hit) begin
            coll = 0;
            tail = 0;
        end else begin
            if (tail) begin
                chk(dout == 1'b0, "R5", "dout after last decision", dout, 0);
                tail = 0;
            end
            if (coll) begin
                if (ccount == 0) chk(strobe == 1'b0, "R4", "strobe second cycle", strobe, 0);
                got = {got[10:0], dout};
                ccount++;
                if (ccount == 12) begin
                    chk(got == cur.word, "R6", "decision word", got, cur.word);
                    coll = 0;
                    tail = 1;
                end
            end
            if (strobe) begin
                strobe_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected strobe", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    chk(chan_sel == cur.ch, "R3", "channel", chan_sel, cur.ch);
                    chk(unipolar == cur.uni, "R3", "polarity", unipolar, cur.uni);
                    chk(single_ended == cur.sgl, "R3", "input mode", single_ended, cur.sgl);
                    chk(pwr_mode == cur.pm, "R3", "power mode", pwr_mode, cur.pm);
                    chk(dout == 1'b0, "R5", "dout during strobe", dout, 0);
                    coll = 1;
                    ccount = 0;
                end
            end
        end
    end

    initial begin
        int sc;
        repeat (3) @(negedge clk);
        chk(dout == 0 && strobe == 0, "R1", "outputs in reset", {dout, strobe}, 0);
        chk(pwr_mode == 2'b00, "R1", "power mode in reset", pwr_mode, 0);
        #1 chk(dout_oe == 0 && strobe_oe == 0, "R7", "oe with cs high", {dout_oe, strobe_oe}, 0);
        @(negedge clk);
        rst = 1'b0;
        cs_n = 1'b0;
        #1 chk(dout_oe == 1 && strobe_oe == 1, "R7", "oe with cs low", {dout_oe, strobe_oe}, 3);

        // R2: leading zeros ignored, then unipolar frame
        idle_cycles(5);
        send_frame(3'd5, 1'b1, 1'b1, 2'b11, 12'hA5C, 14);
        // R6: bipolar frame
        send_frame(3'd2, 1'b0, 1'b0, 2'b01, 12'h3F1, 14);
        // R8: pipelined 16-clock frames
        send_frame(3'd7, 1'b1, 1'b0, 2'b10, 12'h123, 8);
        send_frame(3'd1, 1'b0, 1'b1, 2'b11, 12'hFED, 8);
        send_frame(3'd4, 1'b1, 1'b1, 2'b00, 12'h801, 14);
        chk(strobe_cnt == 5, "R8", "strobes after pipelined frames", strobe_cnt, 5);

        // R8: start bit one clock too early is ignored
        send_frame(3'd6, 1'b1, 1'b0, 2'b11, 12'h0F0, 7);
        @(negedge clk); din = 1'b1;
        @(negedge clk); din = 1'b0;
        idle_cycles(24);
        chk(strobe_cnt == 6, "R8", "early start ignored", strobe_cnt, 6);

        // R2 / R7: ones with cs high start nothing; fields held (R3)
        @(negedge clk); cs_n = 1'b1;
        #1 chk(dout_oe == 0 && strobe_oe == 0, "R7", "oe released", {dout_oe, strobe_oe}, 0);
        for (int i = 0; i < 10; i++) begin @(negedge clk); din = 1'b1; end
        @(negedge clk); din = 1'b0;
        @(negedge clk); cs_n = 1'b0;
        idle_cycles(12);
        chk(strobe_cnt == 6, "R2", "cs high ones ignored", strobe_cnt, 6);
        chk(chan_sel == 3'd6 && pwr_mode == 2'b11, "R3", "fields held", {chan_sel, pwr_mode}, 8'h1B);

        // R7: cs raised during conversion does not stop it
        sc = strobe_cnt;
        send_frame(3'd3, 1'b1, 1'b1, 2'b10, 12'h5A5, 4);
        cs_n = 1'b1;
        idle_cycles(14);
        cs_n = 1'b0;
        chk(strobe_cnt == sc + 1 && exp_q.size() == 0, "R7", "conversion kept with cs high",
            strobe_cnt, sc + 1);

        // R9: shutdown aborts
        send_frame(3'd5, 1'b0, 1'b1, 2'b11, 12'h777, 5);
        shdn_n = 1'b0;
        @(negedge clk); shdn_n = 1'b1;
        chk(pwr_mode == 2'b00 && chan_sel == 3'd0, "R9", "fields cleared", {chan_sel, pwr_mode}, 0);
        got = '0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            got = {got[10:0], dout};
        end
        chk(got == 12'h000 && strobe == 0, "R9", "no bits after abort", got, 0);
        chk(unipolar == 0 && single_ended == 0, "R1", "mode bits cleared", {unipolar, single_ended}, 0);
        send_frame(3'd0, 1'b1, 1'b0, 2'b01, 12'hC3C, 16);
        chk(exp_q.size() == 0, "R9", "frame after shutdown", exp_q.size(), 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule